// File: doc/BRIEF.md
# Random Byte Generator Peripheral

A bus-attached peripheral that produces a stream of 8-bit random values. Software starts or stops continuous generation by writing to trigger offsets, and two hardware pulse inputs do the same. Each new value is latched into a readable data register. It also sets a sticky ready flag and drives a one-cycle pulse on an event output. When the interrupt enable is on, the ready flag raises the interrupt line.

Two generation periods, both given in clock cycles, set how often a value appears. The short raw period applies when bias correction is off. The longer corrected period applies when it is on. In corrected mode the entropy bits go through a pair filter: a bit is kept only when two successive samples differ, and the kept bits are shifted into the output byte. A shortcut option can stop generation as soon as a value is ready. The entropy source is a free-running 16-bit LFSR.

The register port is 32 bits wide. It has a 12-bit byte offset, so the block covers a 0x1000-byte window. Read data is registered.

Top module: `rng_periph`

## Requirements
- R1: A write of any data to offset 0x000, or a one-cycle high on `start_i`, starts generation. The first ready pulse appears exactly P cycles after the clock edge that takes the start. Further pulses follow every P cycles. P is RAW_CYCLES while correction is off.
- R2: A write of any data to offset 0x004, or a one-cycle high on `stop_i`, stops generation. No ready pulse appears after the stop until the next start.
- R3: Each new value sets bit 0 of the ready flag at offset 0x100. In the same cycle, `ready_o` goes high for exactly one cycle. Writing data with bit 0 = 0 to 0x100 clears the flag. Writing bit 0 = 1 there has no effect.
- R4: When bit 0 of offset 0x200 (shortcut) is 1, generation stops after the first ready pulse that follows a start.
- R5: The interrupt enable is bit 0 of offset 0x300, which is written directly. Writing 1 in bit 0 of 0x304 sets the enable, and writing 1 in bit 0 of 0x308 clears it. A 0 in those two writes leaves the enable unchanged. A read of any of the three offsets returns the enable in bit 0.
- R6: `irq_o` is high exactly when the ready flag and the interrupt enable are both 1. It changes in the same cycle as the flag or the enable.
- R7: When bit 0 of offset 0x504 is 1, bias correction is on and the period P becomes FILT_CYCLES.
- R8: A read of offset 0x508 returns the latest value in bits 7:0 and zeros in bits 31:8. The value is 0 after reset.
- R9: If a start and a stop arrive in the same cycle, the stop wins. This holds whether the generator is running or idle.
- R10: A read returns its data one cycle after the request. Reads of unmapped offsets, and of the two trigger offsets, return 0. Writes to unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 12 | Byte offset inside the window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after `rd_en` |
| start_i | input | 1 | Hardware start pulse |
| stop_i | input | 1 | Hardware stop pulse |
| ready_o | output | 1 | One-cycle pulse per new value |
| irq_o | output | 1 | Interrupt line |

## Verification
The bench builds the block with RAW_CYCLES = 6 and FILT_CYCLES = 20. With these short periods, a bench run can cover many back-to-back values in both modes and can measure the exact gap between pulses to the cycle. The short corrected period also lets the bench exercise the shortcut stop and the start/stop collision several times. Idle windows of several whole periods confirm that no stray pulse appears.

// File: rtl/rng_pkg.sv
package rng_pkg;
  localparam logic [11:0] OFF_GO     = 12'h000;
  localparam logic [11:0] OFF_HALT   = 12'h004;
  localparam logic [11:0] OFF_FLAG   = 12'h100;
  localparam logic [11:0] OFF_AUTO   = 12'h200;
  localparam logic [11:0] OFF_IEN    = 12'h300;
  localparam logic [11:0] OFF_IEN_S  = 12'h304;
  localparam logic [11:0] OFF_IEN_C  = 12'h308;
  localparam logic [11:0] OFF_MODE   = 12'h504;
  localparam logic [11:0] OFF_DATA   = 12'h508;
  localparam int          BYTE_W     = 8;
endpackage

// File: rtl/rng_lfsr.sv
module rng_lfsr #(
  parameter int          W    = 16,
  parameter logic [15:0] TAPS = 16'hB400,
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] state
);
  always_ff @(posedge clk) begin
    if (rst) state <= SEED[W-1:0];
    else if (state[0]) state <= (state >> 1) ^ TAPS[W-1:0];
    else state <= state >> 1;
  end
endmodule

// File: rtl/rng_timer.sv
module rng_timer #(
  parameter int RAW_CYCLES  = 64,
  parameter int FILT_CYCLES = 512
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic load,
  input  logic slow,
  output logic expire
);
  localparam int MAXP = (FILT_CYCLES > RAW_CYCLES) ? FILT_CYCLES : RAW_CYCLES;
  localparam int CW   = $clog2(MAXP + 1);
  localparam logic [CW-1:0] RAW_RL  = CW'(RAW_CYCLES - 1);
  localparam logic [CW-1:0] FILT_RL = CW'(FILT_CYCLES - 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] reload;

  assign reload = slow ? FILT_RL : RAW_RL;
  assign expire = active && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (load) cnt <= reload;
    else if (active) begin
      if (cnt == '0) cnt <= reload;
      else cnt <= cnt - 1'b1;
    end
  end

  assert_cnt_range_R7: assert property (@(posedge clk) disable iff (rst)
    cnt <= FILT_RL || cnt <= RAW_RL);
endmodule

// File: rtl/rng_sampler.sv
module rng_sampler #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [BW-1:0] raw_bits,
  input  logic          filt,
  output logic [BW-1:0] sample
);
  logic          phase;
  logic          first;
  logic [BW-1:0] acc;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= 1'b0;
      first <= 1'b0;
      acc   <= '0;
    end else begin
      phase <= ~phase;
      if (!phase) first <= raw_bits[0];
      else if (first != raw_bits[0]) acc <= {acc[BW-2:0], first};
    end
  end

  assign sample = filt ? acc : raw_bits;
endmodule

// File: rtl/rng_periph.sv
module rng_periph #(
  parameter int RAW_CYCLES  = 64,
  parameter int FILT_CYCLES = 512
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [11:0] addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  input  logic        start_i,
  input  logic        stop_i,
  output logic        ready_o,
  output logic        irq_o
);
  import rng_pkg::*;

  logic              running, flag_q, ien_q, auto_q, mode_q;
  logic              flag_d, ien_d;
  logic [BYTE_W-1:0] value_q, sample;
  logic [15:0]       lfsr;
  logic              go_req, halt_req, expire, fire;

  assign go_req   = start_i || (wr_en && addr == OFF_GO);
  assign halt_req = stop_i  || (wr_en && addr == OFF_HALT);
  assign fire     = expire && !halt_req;

  rng_lfsr u_lfsr (.clk(clk), .rst(rst), .state(lfsr));

  rng_timer #(.RAW_CYCLES(RAW_CYCLES), .FILT_CYCLES(FILT_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .active(running), .load(go_req && !halt_req),
    .slow(mode_q), .expire(expire));

  rng_sampler #(.BW(BYTE_W)) u_samp (
    .clk(clk), .rst(rst), .raw_bits(lfsr[BYTE_W-1:0]), .filt(mode_q),
    .sample(sample));

  always_comb begin
    flag_d = flag_q;
    if (fire) flag_d = 1'b1;
    else if (wr_en && addr == OFF_FLAG && !wdata[0]) flag_d = 1'b0;
    ien_d = ien_q;
    if (wr_en) begin
      case (addr)
        OFF_IEN:   ien_d = wdata[0];
        OFF_IEN_S: if (wdata[0]) ien_d = 1'b1;
        OFF_IEN_C: if (wdata[0]) ien_d = 1'b0;
        default:   ien_d = ien_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      flag_q  <= 1'b0;
      ien_q   <= 1'b0;
      auto_q  <= 1'b0;
      mode_q  <= 1'b0;
      value_q <= '0;
      ready_o <= 1'b0;
      irq_o   <= 1'b0;
    end else begin
      if (halt_req) running <= 1'b0;
      else if (go_req) running <= 1'b1;
      else if (fire && auto_q) running <= 1'b0;
      if (fire) value_q <= sample;
      if (wr_en && addr == OFF_AUTO) auto_q <= wdata[0];
      if (wr_en && addr == OFF_MODE) mode_q <= wdata[0];
      flag_q  <= flag_d;
      ien_q   <= ien_d;
      ready_o <= fire;
      irq_o   <= flag_d && ien_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (rd_en) begin
      case (addr)
        OFF_FLAG:                     rdata <= {31'd0, flag_q};
        OFF_AUTO:                     rdata <= {31'd0, auto_q};
        OFF_IEN, OFF_IEN_S, OFF_IEN_C: rdata <= {31'd0, ien_q};
        OFF_MODE:                     rdata <= {31'd0, mode_q};
        OFF_DATA:                     rdata <= {{(32-BYTE_W){1'b0}}, value_q};
        default:                      rdata <= '0;
      endcase
    end
  end

  assert_pulse_sets_flag_R3: assert property (@(posedge clk) disable iff (rst)
    ready_o |-> flag_q);
  assert_pulse_single_R3: assert property (@(posedge clk) disable iff (rst)
    ready_o |=> !ready_o);
  assert_irq_needs_flag_R6: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (flag_q && ien_q));
  assert_halt_wins_R9: assert property (@(posedge clk) disable iff (rst)
    halt_req |=> !running);
  assert_auto_stop_R4: assert property (@(posedge clk) disable iff (rst)
    (fire && auto_q && !go_req) |=> !running);
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !running |=> !ready_o);
endmodule

// File: tb/sim_rng_periph.sv
module sim_rng_periph;
  localparam int RAW  = 6;
  localparam int FILT = 20;

  logic        clk = 1'b0, rst = 1'b1;
  logic        wr_en = 0, rd_en = 0, start_i = 0, stop_i = 0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        ready_o, irq_o;
  int          checks = 0, fails = 0;

  always #10 clk = ~clk;

  rng_periph #(.RAW_CYCLES(RAW), .FILT_CYCLES(FILT)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .start_i(start_i), .stop_i(stop_i),
    .ready_o(ready_o), .irq_o(irq_o));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  task automatic pins(input logic go, input logic halt);
    @(negedge clk); start_i = go; stop_i = halt;
    @(negedge clk); start_i = 0; stop_i = 0;
  endtask

  // cycles until the next pulse, 0 if none within lim
  task automatic gap(input int lim, output int n);
    n = 0;
    for (int k = 1; k <= lim; k++) begin
      @(negedge clk);
      if (ready_o) begin n = k; break; end
    end
  endtask

  task automatic count_pulses(input int lim, output int n);
    n = 0;
    for (int k = 0; k < lim; k++) begin
      @(negedge clk);
      if (ready_o) n++;
    end
  endtask

  function automatic bit is_mapped(input logic [11:0] a);
    return a inside {12'h000, 12'h004, 12'h100, 12'h200, 12'h300,
                     12'h304, 12'h308, 12'h504, 12'h508};
  endfunction

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int n;
    int nz;
    logic ie_m, au_m, md_m;
    void'($urandom(1234));
    repeat (3) @(negedge clk);
    rst = 0;

    // reset state
    chk("R6 irq reset", irq_o, 0);
    chk("R3 pulse reset", ready_o, 0);
    rd(12'h100, d); chk("R3 flag reset", d, 0);
    rd(12'h300, d); chk("R5 ien reset", d, 0);
    rd(12'h508, d); chk("R8 value reset", d, 0);

    // R1 start by write, raw period
    wr(12'h000, 32'h0);
    gap(50, n); chk("R1 first gap", n, RAW);
    gap(50, n); chk("R1 second gap", n, RAW);
    gap(50, n); chk("R1 third gap", n, RAW);
    // R2 stop by write
    wr(12'h004, 32'h0);
    count_pulses(4 * RAW, n); chk("R2 no pulse after stop", n, 0);
    rd(12'h100, d); chk("R3 flag set", d, 1);
    wr(12'h100, 32'h1);
    rd(12'h100, d); chk("R3 write 1 ignored", d, 1);
    wr(12'h100, 32'h0);
    rd(12'h100, d); chk("R3 write 0 clears", d, 0);

    // R6 irq via enable set/clear aliases, start/stop by pins
    wr(12'h304, 32'h1);
    chk("R6 irq low without flag", irq_o, 0);
    pins(1, 0);
    gap(50, n); chk("R1 pin start gap", n, RAW);
    chk("R6 irq with flag", irq_o, 1);
    pins(0, 1);
    count_pulses(3 * RAW, n); chk("R2 pin stop", n, 0);
    wr(12'h308, 32'h1); chk("R6 irq off by clear alias", irq_o, 0);
    wr(12'h304, 32'h1); chk("R6 irq on by set alias", irq_o, 1);
    wr(12'h100, 32'h0); chk("R6 irq off on flag clear", irq_o, 0);
    wr(12'h300, 32'h0);

    // R7 corrected period
    wr(12'h504, 32'h1);
    wr(12'h000, 32'h0);
    gap(100, n); chk("R7 first gap", n, FILT);
    gap(100, n); chk("R7 second gap", n, FILT);
    wr(12'h004, 32'h0);
    count_pulses(2 * FILT, n); chk("R2 stop in corrected mode", n, 0);

    // R4 shortcut
    wr(12'h200, 32'h1);
    wr(12'h000, 32'h0);
    gap(100, n); chk("R4 pulse before auto stop", n, FILT);
    count_pulses(3 * FILT, n); chk("R4 auto stop", n, 0);
    wr(12'h504, 32'h0);
    pins(1, 0);
    gap(50, n); chk("R4 raw pulse before auto stop", n, RAW);
    count_pulses(3 * RAW, n); chk("R4 raw auto stop", n, 0);
    wr(12'h200, 32'h0);

    // R8 value readback
    nz = 0;
    for (int i = 0; i < 4; i++) begin
      wr(12'h000, 32'h0);
      gap(50, n);
      wr(12'h004, 32'h0);
      rd(12'h508, d);
      chk("R8 upper bits zero", d >> 8, 0);
      if (d != 0) nz++;
    end
    chk("R8 some value nonzero", (nz > 0), 1);

    // R9 collision
    pins(1, 1);
    count_pulses(4 * RAW, n); chk("R9 stop wins idle", n, 0);
    wr(12'h000, 32'h0);
    gap(50, n); chk("R9 running before collision", n, RAW);
    pins(1, 1);
    count_pulses(4 * RAW, n); chk("R9 stop wins running", n, 0);

    // R5 / R10 random register traffic
    ie_m = 0; au_m = 0; md_m = 0;
    wr(12'h300, 32'h0);
    for (int i = 0; i < 60; i++) begin
      int op = $urandom_range(0, 4);
      logic [31:0] r = $urandom;
      case (op)
        0: begin
          logic [11:0] a = (r[0]) ? 12'h304 : ((r[1]) ? 12'h308 : 12'h300);
          wr(a, {$urandom} & 32'h3);
          if (a == 12'h300) ie_m = wdata[0];
          else if (a == 12'h304 && wdata[0]) ie_m = 1;
          else if (a == 12'h308 && wdata[0]) ie_m = 0;
          rd(12'h300 + 12'(4 * (r[5:4] % 3)), d);
          chk("R5 enable readback", d, {31'd0, ie_m});
        end
        1: begin
          wr(12'h200, r); au_m = r[0];
          rd(12'h200, d); chk("R4 shortcut readback", d, {31'd0, au_m});
        end
        2: begin
          wr(12'h504, r); md_m = r[0];
          rd(12'h504, d); chk("R7 mode readback", d, {31'd0, md_m});
        end
        default: begin
          logic [11:0] a = {r[11:2], 2'b00};
          if (is_mapped(a)) a = 12'h800;
          wr(a, 32'hFFFF_FFFF);
          rd(a, d); chk("R10 unmapped reads zero", d, 0);
          rd(12'h300, d); chk("R10 unmapped write ignored ien", d, {31'd0, ie_m});
          rd(12'h504, d); chk("R10 unmapped write ignored mode", d, {31'd0, md_m});
          count_pulses(2, n); chk("R10 unmapped write no start", n, 0);
        end
      endcase
    end
    rd(12'h000, d); chk("R10 trigger offset reads zero", d, 0);
    rd(12'h004, d); chk("R10 trigger offset reads zero", d, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule